// File: doc/BRIEF.md
# Control Endpoint Packet Buffer and Handshake

This block holds the eight-byte packet buffer of a USB control endpoint together with its handshake state. Firmware sees a small byte-wide register window: a data port that walks through the buffer one byte per access, a control register, and a receive status register. On the other side sits a simplified token and packet interface from a serial interface engine. The engine reports decoded tokens, received data bytes and the end of each data packet. It takes back either a byte stream or a one-cycle handshake pulse.

For an IN transfer, firmware loads eight bytes through the data port and sets the transmit-ready bit. The next IN token is answered with the buffer contents. The ready bit stays set until the host acknowledges, so a lost packet is sent again on the next IN. An IN token that finds the ready bit clear gets a NAK pulse and no data. For SETUP and OUT transfers, the block stores the received bytes from buffer position zero and drops any beyond the eighth, raising an overflow flag. At the end of the packet it records a 4-bit code naming the token and data toggle, raises a receive-complete flag and pulses an ACK. The flag stays set until firmware clears it. While it is set, OUT packets are refused with NAK, but SETUP packets are still accepted.

Top module: `ctrl_ep_buffer`

## Requirements
- R1: After reset the control register reads 0 (transmit-ready, receive-complete and overflow all clear), the byte pointer is at position 0, and tx_valid, tx_last, hs_ack and hs_nak are all 0.
- R2: An IN token (tok_kind 0) taken while transmit-ready is 1 starts a burst on the next cycle. The burst has tx_valid high for exactly 8 consecutive cycles, carrying buffer bytes 0 to 7 in order on tx_byte, with tx_last high only on the eighth.
- R3: A host_ack pulse after a burst clears transmit-ready and returns the byte pointer to 0.
- R4: An IN token taken while transmit-ready is 0 produces a one-cycle hs_nak pulse on the next cycle, and tx_valid stays 0.
- R5: If another token arrives after a burst with no host_ack in between, transmit-ready stays 1, and a further IN token resends the same 8 bytes.
- R6: When a data packet ends (rx_end, with rx_toggle 0 for DATA0 and 1 for DATA1), hs_ack pulses on the next cycle, receive-complete becomes 1, and status register bits [3:0] hold {setup, out, toggle, not toggle}: 1001 for SETUP/DATA0, 0101 for OUT/DATA0, 0110 for OUT/DATA1. Bits [7:4] read 0.
- R7: fw_sel selects 0 = data port, 1 = control, 2 = status, 3 = reads 0. The control register has bit 0 transmit-ready (read/write), bit 1 receive-complete (write 1 to clear), bit 2 overflow (read only) and bit 3 rewind (write-only, reads 0). Bits [7:4] read 0.
- R8: Each data-port write stores fw_wdata at the pointer, and each data-port read (fw_rd) returns the byte at the pointer. Either access advances the pointer modulo 8. Writing control with bit 0 or bit 3 set returns the pointer to 0.
- R9: A received packet longer than 8 bytes keeps its first 8 bytes, drops the rest, and sets the overflow flag.
- R10: Receive-complete stays 1 until firmware writes 1 to control bit 1, which also clears overflow. While it is 1, an OUT token gets an hs_nak pulse and its bytes change neither the buffer nor the status.
- R11: A SETUP token (tok_kind 2) is accepted even while receive-complete is 1. Reception restarts at byte 0 and replaces the status code.
- R12: After a packet completes, the pointer is at 0, so eight data-port reads return the received bytes from the first one on (tok_kind 1 is OUT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_sel | input | 2 | Firmware register select |
| fw_wr | input | 1 | Firmware write strobe |
| fw_rd | input | 1 | Firmware read strobe (advances the data port) |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Firmware read data for the selected register |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_kind | input | 2 | Token type: 0 IN, 1 OUT, 2 SETUP |
| rx_byte_valid | input | 1 | Received data byte present |
| rx_byte | input | 8 | Received data byte |
| rx_end | input | 1 | End of received data packet |
| rx_toggle | input | 1 | Data toggle of the ending packet (0 DATA0, 1 DATA1) |
| host_ack | input | 1 | Host acknowledged the transmitted packet |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Last byte of the transmit burst |
| hs_ack | output | 1 | Send ACK for a completed received packet |
| hs_nak | output | 1 | Send NAK for a refused token |

## Verification
The retry path is hard to reach from the ports. It needs a full burst followed by a token that arrives with no host acknowledge, and then a second IN token that must repeat the burst byte for byte. Directed sequences build that ordering, along with an OUT that arrives while unread data is waiting, an over-long packet, and a SETUP that overrides a pending receive. Seeded random rounds then mix packet loads, acknowledged and unacknowledged transmits, and packets of 0 to 11 bytes with random toggles. Each round is checked against a byte-level model of the buffer held in the bench.

// File: rtl/cep_pkg.sv
package cep_pkg;

  typedef enum logic [1:0] {
    TK_IN    = 2'd0,
    TK_OUT   = 2'd1,
    TK_SETUP = 2'd2,
    TK_RSVD  = 2'd3
  } tok_kind_e;

  localparam logic [1:0] SEL_DATA   = 2'd0;
  localparam logic [1:0] SEL_CTRL   = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;

  localparam int CTL_READY  = 0;
  localparam int CTL_DONE   = 1;
  localparam int CTL_OVF    = 2;
  localparam int CTL_REWIND = 3;

  // Receive code: {setup, out, toggle, ~toggle}
  function automatic logic [3:0] rx_code(input logic is_setup, input logic toggle);
    return {is_setup, ~is_setup, toggle, ~toggle};
  endfunction

endpackage

// File: rtl/cep_buf_mem.sv
module cep_buf_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata_a = store[raddr_a];
  assign rdata_b = store[raddr_b];

endmodule

// File: rtl/cep_tx_engine.sv
module cep_tx_engine #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] idx,
  output logic          last
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign last = busy && (idx == LAST_IDX);

  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy); // R2

  AST_BURST_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && idx == '0)); // R2

endmodule

// File: rtl/cep_ctrl.sv
module cep_ctrl
  import cep_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fw_sel,
  input  logic          fw_wr,
  input  logic          fw_rd,
  input  logic [DW-1:0] fw_wdata,
  output logic [DW-1:0] fw_rdata,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          rx_byte_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_end,
  input  logic          rx_toggle,
  input  logic          host_ack,
  input  logic          tx_busy,
  output logic          tx_start,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          hs_ack,
  output logic          hs_nak
);

  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  function automatic logic [PW-1:0] ptr_wrap_next(input logic [PW-1:0] p);
    if (p >= PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // State
  logic [PW-1:0] ptr_q, ptr_d;
  logic          tx_ready_q, tx_ready_d;
  logic          rx_done_q, rx_done_d;
  logic          ovf_q, ovf_d;
  logic          rx_active_q;
  logic          rx_setup_q;
  logic          wait_ack_q;
  logic [3:0]    code_q;
  logic          hs_ack_q, hs_nak_q;

  // Named events
  tok_kind_e kind;
  logic in_tok, out_tok, setup_tok;
  logic in_send, in_nak, out_nak, rx_start;
  logic rx_take, rx_store, rx_drop, rx_finish;
  logic ack_take;
  logic fw_ctrl_wr, fw_data_wr, fw_data_rd, fw_rewind, fw_clear_done;

  assign kind      = tok_kind_e'(tok_kind);
  assign in_tok    = tok_valid && (kind == TK_IN);
  assign out_tok   = tok_valid && (kind == TK_OUT);
  assign setup_tok = tok_valid && (kind == TK_SETUP);

  assign in_send  = in_tok && tx_ready_q && !tx_busy && !rx_active_q;
  assign in_nak   = in_tok && !tx_ready_q && !tx_busy;
  assign out_nak  = out_tok && rx_done_q;
  assign rx_start = setup_tok || (out_tok && !rx_done_q);

  assign rx_take   = rx_active_q && rx_byte_valid;
  assign rx_store  = rx_take && (ptr_q < FULL);
  assign rx_drop   = rx_take && (ptr_q >= FULL);
  assign rx_finish = rx_active_q && rx_end;

  assign ack_take = host_ack && wait_ack_q && !tx_busy;

  assign fw_ctrl_wr    = fw_wr && (fw_sel == SEL_CTRL);
  assign fw_data_wr    = fw_wr && (fw_sel == SEL_DATA) && !rx_take;
  assign fw_data_rd    = fw_rd && (fw_sel == SEL_DATA) && !rx_take;
  assign fw_rewind     = fw_ctrl_wr && (fw_wdata[CTL_READY] || fw_wdata[CTL_REWIND]);
  assign fw_clear_done = fw_ctrl_wr && fw_wdata[CTL_DONE];

  assign tx_start = in_send;

  // Buffer write port: received data has priority
  assign mem_we    = rx_store || fw_data_wr;
  assign mem_waddr = ptr_q[AW-1:0];
  assign mem_wdata = rx_store ? rx_byte : fw_wdata;
  assign mem_raddr = ptr_q[AW-1:0];

  // Next-state, later lines take priority
  always_comb begin
    ptr_d = ptr_q;
    if (fw_data_wr || fw_data_rd) ptr_d = ptr_wrap_next(ptr_q);
    if (fw_rewind)                ptr_d = '0;
    if (rx_store)                 ptr_d = ptr_q + 1'b1;
    if (rx_start || rx_finish || ack_take) ptr_d = '0;
  end

  always_comb begin
    tx_ready_d = tx_ready_q;
    if (fw_ctrl_wr) tx_ready_d = fw_wdata[CTL_READY];
    if (ack_take)   tx_ready_d = 1'b0;
  end

  always_comb begin
    rx_done_d = rx_done_q;
    ovf_d     = ovf_q;
    if (fw_clear_done) begin
      rx_done_d = 1'b0;
      ovf_d     = 1'b0;
    end
    if (rx_start) begin
      rx_done_d = 1'b0;
      ovf_d     = 1'b0;
    end
    if (rx_drop)   ovf_d     = 1'b1;
    if (rx_finish) rx_done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      tx_ready_q  <= 1'b0;
      rx_done_q   <= 1'b0;
      ovf_q       <= 1'b0;
      rx_active_q <= 1'b0;
      rx_setup_q  <= 1'b0;
      wait_ack_q  <= 1'b0;
      code_q      <= '0;
      hs_ack_q    <= 1'b0;
      hs_nak_q    <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      tx_ready_q <= tx_ready_d;
      rx_done_q  <= rx_done_d;
      ovf_q      <= ovf_d;
      if (rx_start) begin
        rx_active_q <= 1'b1;
        rx_setup_q  <= setup_tok;
      end else if (rx_finish) begin
        rx_active_q <= 1'b0;
      end
      if (rx_finish) code_q <= rx_code(rx_setup_q, rx_toggle);
      if (tok_valid)     wait_ack_q <= in_send;
      else if (ack_take) wait_ack_q <= 1'b0;
      hs_ack_q <= rx_finish;
      hs_nak_q <= in_nak || out_nak;
    end
  end

  // Firmware read mux
  always_comb begin
    fw_rdata = '0;
    case (fw_sel)
      SEL_DATA: fw_rdata = mem_rdata;
      SEL_CTRL: begin
        fw_rdata[CTL_READY] = tx_ready_q;
        fw_rdata[CTL_DONE]  = rx_done_q;
        fw_rdata[CTL_OVF]   = ovf_q;
      end
      SEL_STATUS: fw_rdata[3:0] = code_q;
      default: fw_rdata = '0;
    endcase
  end

  assign hs_ack = hs_ack_q;
  assign hs_nak = hs_nak_q;

  // Assertions
  AST_ACK_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (!tx_ready_q && ptr_q == '0)); // R3

  AST_NAK_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_nak |=> (hs_nak_q && !tx_busy)); // R4

  AST_RETRY_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_ack_q && tok_valid && !fw_ctrl_wr) |=> tx_ready_q); // R5

  AST_CODE_WELLFORMED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_q |-> ($countones(code_q) == 2)); // R6

  AST_PTR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= FULL); // R9

  AST_NO_WRITE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> !mem_we); // R9

  AST_DROP_FLAGS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_start) |=> ovf_q); // R9

  AST_OUT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_nak && !fw_clear_done) |=> (hs_nak_q && rx_done_q && !rx_active_q)); // R10

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_q && !fw_clear_done && !rx_start) |=> rx_done_q); // R10

  AST_SETUP_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> (rx_active_q && rx_setup_q && ptr_q == '0)); // R11

endmodule

// File: rtl/ctrl_ep_buffer.sv
module ctrl_ep_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fw_sel,
  input  logic          fw_wr,
  input  logic          fw_rd,
  input  logic [DW-1:0] fw_wdata,
  output logic [DW-1:0] fw_rdata,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          rx_byte_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_end,
  input  logic          rx_toggle,
  input  logic          host_ack,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          tx_last,
  output logic          hs_ack,
  output logic          hs_nak
);

  logic          tx_busy, tx_start, tx_end;
  logic [AW-1:0] tx_idx;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata, tx_rdata;

  cep_buf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (mem_raddr),
    .rdata_a (mem_rdata),
    .raddr_b (tx_idx),
    .rdata_b (tx_rdata)
  );

  cep_tx_engine #(.DEPTH(DEPTH)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .busy  (tx_busy),
    .idx   (tx_idx),
    .last  (tx_end)
  );

  cep_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fw_sel        (fw_sel),
    .fw_wr         (fw_wr),
    .fw_rd         (fw_rd),
    .fw_wdata      (fw_wdata),
    .fw_rdata      (fw_rdata),
    .tok_valid     (tok_valid),
    .tok_kind      (tok_kind),
    .rx_byte_valid (rx_byte_valid),
    .rx_byte       (rx_byte),
    .rx_end        (rx_end),
    .rx_toggle     (rx_toggle),
    .host_ack      (host_ack),
    .tx_busy       (tx_busy),
    .tx_start      (tx_start),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata),
    .mem_raddr     (mem_raddr),
    .mem_rdata     (mem_rdata),
    .hs_ack        (hs_ack),
    .hs_nak        (hs_nak)
  );

  assign tx_valid = tx_busy;
  assign tx_byte  = tx_busy ? tx_rdata : '0;
  assign tx_last  = tx_end;

  AST_TX_NOT_DURING_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> !tx_last); // R4

endmodule

// File: tb/ctrl_ep_buffer_bench.sv
module ctrl_ep_buffer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fw_sel = 2'd0;
  logic       fw_wr = 1'b0, fw_rd = 1'b0;
  logic [7:0] fw_wdata = 8'h00;
  logic [7:0] fw_rdata;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'd0;
  logic       rx_byte_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_end = 1'b0, rx_toggle = 1'b0, host_ack = 1'b0;
  logic       tx_valid, tx_last, hs_ack, hs_nak;
  logic [7:0] tx_byte;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] exp_mem [8];
  logic       exp_ready, exp_done, exp_ovf;
  logic [3:0] exp_code;

  ctrl_ep_buffer u_ctrl_ep_buffer (
    .clk(clk), .rst_n(rst_n), .fw_sel(fw_sel), .fw_wr(fw_wr), .fw_rd(fw_rd),
    .fw_wdata(fw_wdata), .fw_rdata(fw_rdata), .tok_valid(tok_valid),
    .tok_kind(tok_kind), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_toggle(rx_toggle), .host_ack(host_ack),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
    .hs_ack(hs_ack), .hs_nak(hs_nak)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [3:0] model_code(input bit setup, input bit tog);
    if (setup) return tog ? 4'b1010 : 4'b1001;
    return tog ? 4'b0110 : 4'b0101;
  endfunction

  function automatic logic [7:0] model_ctrl();
    return {5'b0, exp_ovf, exp_done, exp_ready};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
    end
  endtask

  task automatic fw_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    fw_sel = sel; fw_wdata = d; fw_wr = 1'b1;
    @(negedge clk);
    fw_wr = 1'b0;
  endtask

  task automatic fw_read(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    fw_sel = sel; fw_rd = 1'b1;
    #1 d = fw_rdata;
    @(negedge clk);
    fw_rd = 1'b0;
  endtask

  task automatic load_packet(input logic [7:0] b [8]);
    fw_write(2'd1, 8'h08);               // rewind, ready 0 (R8)
    exp_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      fw_write(2'd0, b[i]);
      exp_mem[i] = b[i];
    end
    fw_write(2'd1, 8'h01);
    exp_ready = 1'b1;
  endtask

  task automatic send_token(input logic [1:0] k);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = k;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic do_in();
    send_token(2'd0);
    if (exp_ready) begin
      for (int i = 0; i < 8; i++) begin
        chk("R2", "tx_valid", tx_valid, 1);
        chk("R2", "tx_byte", tx_byte, exp_mem[i]);
        chk("R2", "tx_last", tx_last, (i == 7));
        @(negedge clk);
      end
      chk("R2", "tx_valid after burst", tx_valid, 0);
    end else begin
      chk("R4", "hs_nak", hs_nak, 1);
      chk("R4", "tx_valid on nak", tx_valid, 0);
      @(negedge clk);
      chk("R4", "hs_nak width", hs_nak, 0);
      chk("R4", "tx_valid after nak", tx_valid, 0);
    end
  endtask

  task automatic do_ack();
    @(negedge clk);
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
    exp_ready = 1'b0;
  endtask

  task automatic rx_packet(input bit setup, input bit tog, input int n, input logic [7:0] b [12]);
    bit accept;
    accept = setup || !exp_done;
    send_token(setup ? 2'd2 : 2'd1);
    if (!accept) chk("R10", "hs_nak on OUT", hs_nak, 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_byte_valid = 1'b1; rx_byte = b[i];
    end
    @(negedge clk);
    rx_byte_valid = 1'b0; rx_end = 1'b1; rx_toggle = tog;
    @(negedge clk);
    rx_end = 1'b0;
    chk(accept ? "R6" : "R10", "hs_ack", hs_ack, accept);
    if (accept) begin
      for (int i = 0; i < 8; i++) if (i < n) exp_mem[i] = b[i];
      exp_ovf  = (n > 8);
      exp_done = 1'b1;
      exp_code = model_code(setup, tog);
    end
  endtask

  task automatic verify_state(input string req);
    logic [7:0] d;
    fw_read(2'd1, d);
    chk(req, "control reg", d, model_ctrl());
    fw_read(2'd2, d);
    chk(req, "status reg", d, {4'b0, exp_code});
    for (int i = 0; i < 8; i++) begin
      fw_read(2'd0, d);
      chk(req, "data port byte", d, exp_mem[i]);
    end
  endtask

  initial begin
    logic [7:0] pk [8];
    logic [7:0] rb [12];
    logic [7:0] d;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    exp_ready = 0; exp_done = 0; exp_ovf = 0; exp_code = 4'h0;
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "tx_last", tx_last, 0);
    chk("R1", "hs_ack", hs_ack, 0);
    chk("R1", "hs_nak", hs_nak, 0);
    fw_read(2'd1, d);
    chk("R1", "control reg", d, 8'h00);

    // R7 rewind bit reads 0, unused select reads 0
    fw_write(2'd1, 8'h08);
    fw_read(2'd1, d);
    chk("R7", "rewind readback", d, 8'h00);
    fw_read(2'd3, d);
    chk("R7", "select 3", d, 8'h00);

    // R4 IN with nothing ready
    do_in();

    // R8 data port round trip with wrap
    for (int i = 0; i < 8; i++) pk[i] = 8'hA0 + 8'(i);
    load_packet(pk);
    fw_write(2'd1, 8'h09);               // rewind, keep ready
    for (int i = 0; i < 8; i++) begin
      fw_read(2'd0, d);
      chk("R8", "readback", d, pk[i]);
    end
    fw_read(2'd0, d);
    chk("R8", "pointer wrap", d, pk[0]);

    // R2 burst, R5 retry without ack, R3 ack
    do_in();
    fw_read(2'd1, d);
    chk("R5", "ready kept without ack", d, model_ctrl());
    do_in();
    do_ack();
    fw_read(2'd1, d);
    chk("R3", "ready cleared by ack", d, model_ctrl());
    fw_read(2'd0, d);
    chk("R3", "pointer reset by ack", d, pk[0]);
    do_in();

    // R6/R12 OUT DATA1 of 5 bytes
    for (int i = 0; i < 12; i++) rb[i] = 8'h30 + 8'(i);
    rx_packet(1'b0, 1'b1, 5, rb);
    verify_state("R12");

    // R10 OUT while unread: refused, nothing changes
    for (int i = 0; i < 12; i++) rb[i] = 8'hE0 + 8'(i);
    rx_packet(1'b0, 1'b0, 4, rb);
    verify_state("R10");

    // R11 SETUP overrides pending receive
    for (int i = 0; i < 12; i++) rb[i] = 8'h50 + 8'(i);
    rx_packet(1'b1, 1'b0, 8, rb);
    verify_state("R11");

    // R10 firmware clears done
    fw_write(2'd1, 8'h02);
    exp_done = 1'b0; exp_ovf = 1'b0;
    fw_read(2'd1, d);
    chk("R10", "done cleared", d, model_ctrl());

    // R9 overflow
    for (int i = 0; i < 12; i++) rb[i] = 8'h70 + 8'(i);
    rx_packet(1'b0, 1'b0, 11, rb);
    verify_state("R9");
    fw_write(2'd1, 8'h02);
    exp_done = 1'b0; exp_ovf = 1'b0;

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      if ($urandom_range(1, 0) == 0) begin
        for (int i = 0; i < 8; i++) pk[i] = 8'($urandom);
        load_packet(pk);
        do_in();
        if ($urandom_range(1, 0) == 1) do_in();   // R5 retry
        do_ack();
        do_in();                                  // R4 after ack
      end else begin
        int n;
        bit st, tg;
        n  = $urandom_range(11, 0);
        st = 1'($urandom_range(1, 0));
        tg = 1'($urandom_range(1, 0));
        for (int i = 0; i < 12; i++) rb[i] = 8'($urandom);
        rx_packet(st, tg, n, rb);
        verify_state("R6");
        if ($urandom_range(2, 0) != 0) begin
          fw_write(2'd1, 8'h02);
          exp_done = 1'b0; exp_ovf = 1'b0;
        end
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule